// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block counts hardware events for performance monitoring. It holds eight 64-bit counters. Each counter has an 8-bit event code that picks one line of a wide event-strobe input, or picks the clock itself when the code is zero. Software controls the counters through a small memory-mapped register port. A single global run bit and a per-counter enable mask together decide which counters advance.

When a counter rolls over from all ones to zero, it latches a status bit. That status can raise one level-sensitive interrupt line. Each source has a mask bit, and a mask bit of 1 blocks that source. Software acknowledges an overflow by writing a one-hot (or multi-hot) pattern to a separate clear register. The unit also reports a fixed version word. It exports a power-management disable bit taken from a configuration register.

Each register access takes one cycle. A read or write strobe is sampled on a clock edge, and `ready` with the read data follows in the next cycle. Counters are 64-bit registers. All other registers are 32 bits wide and sit in the low half of the data bus.

Top module: `evctr_unit`

## Requirements
- R1: Counter n (0..7) is one 64-bit read/write register at byte address 0x1D00 + 8*n. A write to a counter in the same cycle as an increment stores the written value, and the increment is dropped.
- R2: The event code of counter n is the 8-bit field at bits [8*(n mod 4)+7 : 8*(n mod 4)] of the select register at 0x1C80 (counters 0..3) or 0x1C84 (counters 4..7). Both registers read back as written.
- R3: An event code of 0x00 advances the counter on every clock edge. A nonzero code c advances it on each edge where bit c of `ev_strobe` is 1.
- R4: A counter advances only while both of these are 1: bit 0 of the control register at 0x1C00, and bit n of the enable register at 0x1C04. Otherwise it holds its value.
- R5: A counter rolling over from all ones to zero sets bit n of the status register at 0x1C78. Status is read-only, and writes to 0x1C78 leave it unchanged.
- R6: Writing a word to 0x1C7C clears every status bit whose write bit is 1. Bits written as 0 are unaffected. A rollover in the same cycle as a clear of that bit leaves the bit set.
- R7: The mask register at 0x1C70 blocks counter n's interrupt when bit n is 1. `irq` is the OR over all n of (status n AND NOT mask n).
- R8: Address 0x1CF0 reads the VERSION_ID parameter, and writes there are ignored. Bit 9 of the configuration register at 0x0534 is the only stored bit there, and it drives `pm_disable`.
- R9: Reads of unmapped addresses, including misaligned ones, return zero, and writes there change nothing. `ready` is 1 in exactly the cycle after each read or write strobe, and `rdata` carries the read value in that cycle.
- R10: After reset all counters, enables, the run bit, status and the configuration bit are 0, all mask bits are 1, and `irq`, `pm_disable` and `ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Byte address |
| wdata | input | 64 | Write data (32-bit registers use bits 31:0) |
| rdata | output | 64 | Read data, valid while ready is 1 |
| ready | output | 1 | Access complete, one cycle after a strobe |
| ev_strobe | input | 256 | Event strobe lines, selected by event code |
| irq | output | 1 | Level overflow interrupt |
| pm_disable | output | 1 | Power-management disable control |

## Verification
Several properties are checked on every cycle. A counter write wins over an increment. A counter holds while it is gated off and steps by one under code zero. A rollover lands on zero and latches status. A clear drops only the written bits unless a rollover coincides. A fully masked unit never interrupts, and `ready` follows each strobe. The bench scenarios cover the rest: event-code packing across the two select registers, random event patterns matched against a reference model, mask and clear sequences, and unmapped-address isolation. These behaviours can be seen only by comparing whole register contents after a sequence of accesses.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    localparam int NCNT          = 8;
    localparam int CNT_W         = 64;
    localparam int EV_W          = 256;
    localparam int CODE_W        = $clog2(EV_W);
    localparam int ADDR_W        = 16;
    localparam int DATA_W        = 64;
    localparam int REG_W         = 32;
    localparam int CODES_PER_REG = REG_W / CODE_W;
    localparam int NSEL          = NCNT / CODES_PER_REG;
    localparam int IDX_W         = $clog2(NCNT);
    localparam int PM_BIT        = 9;

    localparam logic [ADDR_W-1:0] A_RUN   = 16'h1C00;
    localparam logic [ADDR_W-1:0] A_CEN   = 16'h1C04;
    localparam logic [ADDR_W-1:0] A_MASK  = 16'h1C70;
    localparam logic [ADDR_W-1:0] A_STAT  = 16'h1C78;
    localparam logic [ADDR_W-1:0] A_CLR   = 16'h1C7C;
    localparam logic [ADDR_W-1:0] A_SEL0  = 16'h1C80;
    localparam logic [ADDR_W-1:0] A_VER   = 16'h1CF0;
    localparam logic [ADDR_W-1:0] A_CNT0  = 16'h1D00;
    localparam logic [ADDR_W-1:0] A_CFG   = 16'h0534;

    typedef enum logic [3:0] {
        RK_NONE, RK_RUN, RK_CEN, RK_MASK, RK_STAT,
        RK_CLR, RK_SEL, RK_VER, RK_CFG, RK_CNT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.kind = RK_NONE;
        d.idx  = '0;
        case (a)
            A_RUN:   d.kind = RK_RUN;
            A_CEN:   d.kind = RK_CEN;
            A_MASK:  d.kind = RK_MASK;
            A_STAT:  d.kind = RK_STAT;
            A_CLR:   d.kind = RK_CLR;
            A_VER:   d.kind = RK_VER;
            A_CFG:   d.kind = RK_CFG;
            default: d.kind = RK_NONE;
        endcase
        for (int i = 0; i < NSEL; i++) begin
            if (a == A_SEL0 + ADDR_W'(4 * i)) begin
                d.kind = RK_SEL;
                d.idx  = IDX_W'(i);
            end
        end
        for (int i = 0; i < NCNT; i++) begin
            if (a == A_CNT0 + ADDR_W'(8 * i)) begin
                d.kind = RK_CNT;
                d.idx  = IDX_W'(i);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/evctr_slice.sv
module evctr_slice #(
    parameter int CNT_W  = 64,
    parameter int EV_W   = 256,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] code,
    input  logic [EV_W-1:0]   ev_strobe,
    input  logic              wr_hit,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);

    logic [CNT_W-1:0] cnt_q;
    logic             ev_hit;
    logic             inc;

    // Code zero is the free-running cycle event
    assign ev_hit = (code == '0) | ev_strobe[code];
    assign inc    = inc_en & ev_hit;
    assign wrap   = inc & ~wr_hit & (&cnt_q);
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_hit) begin
            cnt_q <= wdata;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_write_wins_R1: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> cnt_q == $past(wdata));

    assert_hold_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!inc_en && !wr_hit) |=> $stable(cnt_q));

    assert_cycle_step_R3: assert property (@(posedge clk) disable iff (rst)
        (inc_en && code == '0 && !wr_hit) |=> cnt_q == $past(cnt_q) + 1'b1);

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);

endmodule

// File: rtl/evctr_irq.sv
module evctr_irq #(
    parameter int NCNT = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCNT-1:0] wrap,
    input  logic            clr_we,
    input  logic [NCNT-1:0] clr_bits,
    input  logic [NCNT-1:0] mask,
    output logic [NCNT-1:0] status,
    output logic            irq
);

    logic [NCNT-1:0] status_q;

    assign status = status_q;
    assign irq    = |(status_q & ~mask);

    genvar g;
    generate
        for (g = 0; g < NCNT; g++) begin : g_stat
            always_ff @(posedge clk) begin
                if (rst) begin
                    status_q[g] <= 1'b0;
                end else if (wrap[g]) begin
                    status_q[g] <= 1'b1;
                end else if (clr_we && clr_bits[g]) begin
                    status_q[g] <= 1'b0;
                end
            end

            assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (rst)
                wrap[g] |=> status_q[g]);

            assert_clear_drops_R6: assert property (@(posedge clk) disable iff (rst)
                (clr_we && clr_bits[g] && !wrap[g]) |=> !status_q[g]);

            assert_status_holds_R6: assert property (@(posedge clk) disable iff (rst)
                (!wrap[g] && !(clr_we && clr_bits[g])) |=> $stable(status_q[g]));
        end
    endgenerate

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq);

endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
    import evctr_pkg::*;
#(
    parameter logic [REG_W-1:0] VERSION_ID = 32'h0000_0030
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    input  logic [EV_W-1:0]   ev_strobe,
    output logic              irq,
    output logic              pm_disable
);

    reg_dec_t          dec;
    logic              run_q;
    logic [NCNT-1:0]   cen_q;
    logic [NCNT-1:0]   mask_q;
    logic [CODE_W-1:0] evsel_q [NCNT];
    logic              pmdis_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ready_q;
    logic [DATA_W-1:0] rd_mux;
    logic [REG_W-1:0]  sel_word;
    logic [CNT_W-1:0]  cnt_w [NCNT];
    logic [NCNT-1:0]   wrap_w;
    logic [NCNT-1:0]   status_w;
    logic              wr_run, wr_cen, wr_mask, wr_sel, wr_cfg, wr_clr, wr_cnt;

    assign dec     = decode_addr(addr);
    assign wr_run  = wr_en && dec.kind == RK_RUN;
    assign wr_cen  = wr_en && dec.kind == RK_CEN;
    assign wr_mask = wr_en && dec.kind == RK_MASK;
    assign wr_sel  = wr_en && dec.kind == RK_SEL;
    assign wr_cfg  = wr_en && dec.kind == RK_CFG;
    assign wr_clr  = wr_en && dec.kind == RK_CLR;
    assign wr_cnt  = wr_en && dec.kind == RK_CNT;

    // Control and configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            cen_q   <= '0;
            mask_q  <= '1;
            pmdis_q <= 1'b0;
            for (int i = 0; i < NCNT; i++) evsel_q[i] <= '0;
        end else begin
            if (wr_run)  run_q   <= wdata[0];
            if (wr_cen)  cen_q   <= wdata[NCNT-1:0];
            if (wr_mask) mask_q  <= wdata[NCNT-1:0];
            if (wr_cfg)  pmdis_q <= wdata[PM_BIT];
            if (wr_sel) begin
                for (int k = 0; k < CODES_PER_REG; k++) begin
                    evsel_q[IDX_W'((int'(dec.idx) % NSEL) * CODES_PER_REG + k)]
                        <= wdata[k*CODE_W +: CODE_W];
                end
            end
        end
    end

    // Packed view of the addressed select register
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < CODES_PER_REG; k++) begin
            sel_word[k*CODE_W +: CODE_W] =
                evsel_q[IDX_W'((int'(dec.idx) % NSEL) * CODES_PER_REG + k)];
        end
    end

    always_comb begin
        case (dec.kind)
            RK_RUN:  rd_mux = DATA_W'(run_q);
            RK_CEN:  rd_mux = DATA_W'(cen_q);
            RK_MASK: rd_mux = DATA_W'(mask_q);
            RK_STAT: rd_mux = DATA_W'(status_w);
            RK_SEL:  rd_mux = DATA_W'(sel_word);
            RK_VER:  rd_mux = DATA_W'(VERSION_ID);
            RK_CFG:  rd_mux = DATA_W'(pmdis_q) << PM_BIT;
            RK_CNT:  rd_mux = DATA_W'(cnt_w[dec.idx]);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= rd_en | wr_en;
            rdata_q <= rd_en ? rd_mux : '0;
        end
    end

    assign rdata      = rdata_q;
    assign ready      = ready_q;
    assign pm_disable = pmdis_q;

    genvar g;
    generate
        for (g = 0; g < NCNT; g++) begin : g_cnt
            evctr_slice #(
                .CNT_W (CNT_W),
                .EV_W  (EV_W),
                .CODE_W(CODE_W)
            ) u_slice (
                .clk      (clk),
                .rst      (rst),
                .inc_en   (run_q & cen_q[g]),
                .code     (evsel_q[g]),
                .ev_strobe(ev_strobe),
                .wr_hit   (wr_cnt && dec.idx == IDX_W'(g)),
                .wdata    (wdata[CNT_W-1:0]),
                .cnt      (cnt_w[g]),
                .wrap     (wrap_w[g])
            );
        end
    endgenerate

    evctr_irq #(.NCNT(NCNT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap_w),
        .clr_we  (wr_clr),
        .clr_bits(wdata[NCNT-1:0]),
        .mask    (mask_q),
        .status  (status_w),
        .irq     (irq)
    );

    assert_ready_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |=> ready);

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !(rd_en || wr_en) |=> !ready);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.kind == RK_NONE) |=> rdata == '0);

    assert_version_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.kind == RK_VER) |=> rdata == DATA_W'(VERSION_ID));

    assert_pm_out_R8: assert property (@(posedge clk) disable iff (rst)
        wr_cfg |=> pm_disable == $past(wdata[PM_BIT]));

    assert_reset_mask_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && !irq && !pm_disable));

endmodule

// File: tb/evctr_unit_tb_top.sv
module evctr_unit_tb_top;

    localparam logic [15:0] T_RUN  = 16'h1C00;
    localparam logic [15:0] T_CEN  = 16'h1C04;
    localparam logic [15:0] T_MASK = 16'h1C70;
    localparam logic [15:0] T_STAT = 16'h1C78;
    localparam logic [15:0] T_CLR  = 16'h1C7C;
    localparam logic [15:0] T_SEL0 = 16'h1C80;
    localparam logic [15:0] T_SEL1 = 16'h1C84;
    localparam logic [15:0] T_VER  = 16'h1CF0;
    localparam logic [15:0] T_CNT0 = 16'h1D00;
    localparam logic [15:0] T_CFG  = 16'h0534;
    localparam logic [31:0] T_VERSION = 32'h0000_0030;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en, rd_en;
    logic [15:0]  addr;
    logic [63:0]  wdata;
    logic [63:0]  rdata;
    logic         ready;
    logic [255:0] ev_strobe;
    logic         irq;
    logic         pm_disable;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0]  m_cnt [8];
    logic [7:0]   m_code [8];
    logic [7:0]   m_en, m_stat, m_mask;
    logic         m_gen;
    logic [255:0] ev_next;

    always #2 clk = ~clk;

    evctr_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .ev_strobe(ev_strobe),
        .irq(irq), .pm_disable(pm_disable)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input bit w, input bit r, input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; ev_strobe = ev_next;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 16'h0, 64'h0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        bus(1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        bus(1'b0, 1'b1, a, 64'h0);
        d = rdata;
    endtask

    function automatic logic [255:0] rand_ev();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic model_step(input logic [255:0] v);
        for (int n = 0; n < 8; n++) begin
            if (m_gen && m_en[n] && (m_code[n] == 8'h00 || v[m_code[n]])) begin
                if (&m_cnt[n]) m_stat[n] = 1'b1;
                m_cnt[n] = m_cnt[n] + 64'd1;
            end
        end
    endtask

    task automatic write_sel();
        wr(T_SEL0, {32'h0, m_code[3], m_code[2], m_code[1], m_code[0]});
        wr(T_SEL1, {32'h0, m_code[7], m_code[6], m_code[5], m_code[4]});
    endtask

    task automatic write_cnt(input int n, input logic [63:0] v);
        wr(T_CNT0 + 16'(8 * n), v);
        m_cnt[n] = v;
    endtask

    task automatic run_window(input int len, input bit random_ev);
        ev_next = '0;
        wr(T_RUN, 64'h1);
        m_gen = 1'b1;
        for (int i = 0; i < len; i++) begin
            ev_next = random_ev ? rand_ev() : '0;
            idle();
            model_step(ev_next);
        end
        ev_next = '0;
        wr(T_RUN, 64'h0);
        model_step(ev_next);
        m_gen = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [63:0] d;
        for (int n = 0; n < 8; n++) begin
            rd(T_CNT0 + 16'(8 * n), d);
            chk($sformatf("R3/R4 %s counter %0d", tag, n), d, m_cnt[n]);
        end
        rd(T_STAT, d);
        chk($sformatf("R5 %s status", tag), d, {56'h0, m_stat});
        chk($sformatf("R7 %s irq", tag), {63'h0, irq}, {63'h0, |(m_stat & ~m_mask)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        ev_strobe = '0; ev_next = '0;
        for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_code[n] = '0; end
        m_en = '0; m_stat = '0; m_mask = 8'hFF; m_gen = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle();

        // R10: reset state
        chk("R10 irq", {63'h0, irq}, 64'h0);
        chk("R10 pm_disable", {63'h0, pm_disable}, 64'h0);
        chk("R10 ready idle", {63'h0, ready}, 64'h0);
        rd(T_MASK, d);  chk("R10 mask", d, 64'hFF);
        chk("R9 ready after read", {63'h0, ready}, 64'h1);
        rd(T_RUN, d);   chk("R10 run", d, 64'h0);
        rd(T_CEN, d);   chk("R10 enables", d, 64'h0);
        rd(T_STAT, d);  chk("R10 status", d, 64'h0);
        rd(T_CNT0 + 16'h38, d); chk("R10 counter7", d, 64'h0);
        idle();
        chk("R9 ready drops", {63'h0, ready}, 64'h0);

        // R8: version and configuration bit
        rd(T_VER, d); chk("R8 version", d, {32'h0, T_VERSION});
        wr(T_VER, 64'hFFFF_FFFF);
        rd(T_VER, d); chk("R8 version write ignored", d, {32'h0, T_VERSION});
        wr(T_CFG, 64'hFFFF_FFFF);
        rd(T_CFG, d); chk("R8 cfg readback", d, 64'h200);
        chk("R8 pm_disable set", {63'h0, pm_disable}, 64'h1);
        wr(T_CFG, 64'h0);
        chk("R8 pm_disable clear", {63'h0, pm_disable}, 64'h0);

        // R2: select packing
        for (int n = 0; n < 8; n++) m_code[n] = 8'(8'h11 * (n + 1));
        write_sel();
        rd(T_SEL0, d); chk("R2 sel0 packing", d, 64'h4433_2211);
        rd(T_SEL1, d); chk("R2 sel1 packing", d, 64'h8877_6655);

        // R1: counter register map
        for (int n = 0; n < 8; n++) write_cnt(n, {32'hA5A5_0000 | 32'(n), 32'h1234_5678 + 32'(n)});
        for (int n = 0; n < 8; n++) begin
            rd(T_CNT0 + 16'(8 * n), d);
            chk($sformatf("R1 counter %0d readback", n), d, m_cnt[n]);
        end

        // R4: per-counter enable without the run bit does nothing
        m_en = 8'hFF; wr(T_CEN, 64'hFF);
        ev_next = '1;
        repeat (5) idle();
        ev_next = '0;
        check_all("no run bit");

        // R9: unmapped and misaligned addresses
        rd(16'h1C08, d); chk("R9 unmapped read", d, 64'h0);
        rd(T_CNT0 + 16'h40, d); chk("R9 past last counter", d, 64'h0);
        rd(T_CNT0 + 16'h4, d); chk("R9 misaligned counter", d, 64'h0);
        wr(16'h1C10, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(T_CNT0 + 16'h2, 64'h0);
        wr(16'h1C01, 64'h1);
        rd(T_RUN, d);  chk("R9 run untouched", d, 64'h0);
        rd(T_CEN, d);  chk("R9 enables untouched", d, 64'hFF);
        rd(T_MASK, d); chk("R9 mask untouched", d, 64'hFF);
        rd(T_CNT0, d); chk("R9 counter0 untouched", d, m_cnt[0]);

        // R3/R5/R7: directed rollover on counter 3 with code zero
        for (int n = 0; n < 8; n++) m_code[n] = 8'h00;
        write_sel();
        m_en = 8'h08; wr(T_CEN, 64'h08);
        write_cnt(3, 64'hFFFF_FFFF_FFFF_FFFE);
        run_window(1, 1'b0);
        rd(T_CNT0 + 16'h18, d); chk("R5 counter3 wrapped", d, 64'h0);
        rd(T_STAT, d); chk("R5 status bit3", d, 64'h08);
        chk("R7 masked irq low", {63'h0, irq}, 64'h0);
        m_mask = 8'hF7; wr(T_MASK, 64'hF7);
        chk("R7 unmasked irq high", {63'h0, irq}, 64'h1);
        wr(T_STAT, 64'h0);
        rd(T_STAT, d); chk("R5 status write ignored", d, 64'h08);
        wr(T_CLR, 64'h20);
        rd(T_STAT, d); chk("R6 zero bits no effect", d, 64'h08);
        chk("R6 irq still high", {63'h0, irq}, 64'h1);
        wr(T_CLR, 64'h08); m_stat = 8'h00;
        rd(T_STAT, d); chk("R6 cleared", d, 64'h0);
        chk("R7 irq low after clear", {63'h0, irq}, 64'h0);

        // R6: rollover coincident with clear keeps status set
        m_en = 8'h02; wr(T_CEN, 64'h02);
        write_cnt(1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(T_RUN, 64'h1); m_gen = 1'b1;
        wr(T_CLR, 64'h02); m_stat = m_stat & ~8'h02; model_step('0);
        wr(T_RUN, 64'h0); model_step('0); m_gen = 1'b0;
        rd(T_STAT, d); chk("R6 set wins over clear", d, 64'h02);
        rd(T_CNT0 + 16'h8, d); chk("R6 counter1 after wrap", d, 64'h1);
        wr(T_CLR, 64'hFF); m_stat = '0;

        // R1: write in same cycle as increment
        m_en = 8'h01; wr(T_CEN, 64'h01);
        write_cnt(0, 64'd5);
        wr(T_RUN, 64'h1); m_gen = 1'b1;
        write_cnt(0, 64'd100);
        wr(T_RUN, 64'h0); model_step('0); m_gen = 1'b0;
        rd(T_CNT0, d); chk("R1 write wins over increment", d, 64'd101);

        // R3/R4/R5/R7: random rounds against the model
        for (int r = 0; r < 24; r++) begin
            for (int n = 0; n < 8; n++)
                m_code[n] = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            write_sel();
            m_en = 8'($urandom); wr(T_CEN, {56'h0, m_en});
            m_mask = 8'($urandom); wr(T_MASK, {56'h0, m_mask});
            for (int n = 0; n < 8; n++) begin
                if ($urandom % 3 == 0)
                    write_cnt(n, 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16));
                else
                    write_cnt(n, {$urandom, $urandom});
            end
            run_window(5 + int'($urandom % 26), 1'b1);
            check_all($sformatf("round %0d", r));
            d = {56'h0, 8'($urandom)};
            wr(T_CLR, d); m_stat = m_stat & ~d[7:0];
            rd(T_STAT, d); chk($sformatf("R6 round %0d clear", r), d, {56'h0, m_stat});
        end
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule